// File: doc/BRIEF.md
# Double-Buffered Bidirectional Host Data Port

This block moves 16-bit words between an embedded core and an external host that sees the data as 8-bit bytes. It carries traffic both ways. Going out, the core writes a word into a transmit register, and that word then passes on its own into a pair of host-readable byte registers. Coming in, the host writes two bytes into a pair of transmit byte registers, and that pair then passes on its own into a core-readable receive register.

Every stage keeps its own flag. The core side has a transmit-empty flag and a receive-full flag. The host side has a transmit-empty flag and a receive-full flag. A word advances to the next stage in a single clock cycle as soon as the source stage holds data and the destination stage is free. The advance then marks the source as empty and the destination as full.

On the host side, the low byte is the access that finishes a transaction: writing it commits a word, and reading it frees the receive pair. Each direction drives its own interrupt request to the core, and each request has its own enable.

Top module: `hostport_xchg`

## Requirements
- R1: After reset, core_tx_empty and host_tx_empty are 1, core_rx_full and host_rx_full are 0, every data register holds zero (so core_rdata and host_rdata read 0), and both interrupt outputs are 0.
- R2: A cycle with core_wr high loads core_wdata into the core transmit register, and core_tx_empty reads 0 after that clock edge.
- R3: A word moves from the core transmit register to the host receive pair on the first clock edge at which core_tx_empty is 0 and host_rx_full is 0. After that edge, core_tx_empty is 1 and host_rx_full is 1. Afterwards, host_rdata shows bits 15:8 when host_sel is 1 and bits 7:0 when host_sel is 0.
- R4: A host_rd with host_sel=0 clears host_rx_full. A host_rd with host_sel=1 leaves host_rx_full unchanged.
- R5: core_tx_irq is 1 exactly when core_tx_empty and core_tx_ie are both 1.
- R6: A host_wr with host_sel=1 loads host_wdata into the high transmit byte and leaves host_tx_empty unchanged. A host_wr with host_sel=0 loads the low transmit byte and makes host_tx_empty 0.
- R7: A word moves from the host transmit pair into the core receive register on the first clock edge at which host_tx_empty is 0 and core_rx_full is 0. After that edge, host_tx_empty is 1, core_rx_full is 1, and core_rdata holds {high byte, low byte}.
- R8: A cycle with core_rd high clears core_rx_full. core_rx_irq is 1 exactly when core_rx_full and core_rx_ie are both 1.
- R9: A core write while core_tx_empty is 0 replaces the pending word. No error indication is raised, and the newer word is the one the host later receives.
- R10: When a core write lands on the same edge as an outgoing transfer, the host receives the older word, the new word stays pending, and core_tx_empty remains 0.
- R11: While a destination stage is full and not being freed, its flag and its data stay unchanged, whatever the source stage holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| core_wr | input | 1 | Core write strobe to the transmit register |
| core_rd | input | 1 | Core read strobe of the receive register; clears core_rx_full |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core receive register contents |
| core_tx_ie | input | 1 | Transmit interrupt enable |
| core_rx_ie | input | 1 | Receive interrupt enable |
| core_tx_empty | output | 1 | Core transmit register is free |
| core_rx_full | output | 1 | Core receive register holds unread data |
| core_tx_irq | output | 1 | Transmit interrupt request |
| core_rx_irq | output | 1 | Receive interrupt request |
| host_sel | input | 1 | Host byte select: 1 = high byte, 0 = low byte |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected host receive byte |
| host_tx_empty | output | 1 | Host transmit pair is free |
| host_rx_full | output | 1 | Host receive pair holds unread data |

## Verification
Two actions can fall on the same clock edge: a fresh load into a source stage, from a core write or a host low-byte write, and the automatic transfer out of that same stage. The bench forces this case directly. It writes two core words on back-to-back cycles, so that the second write meets the transfer of the first. The random phase then produces the same collision many times in both directions. The outcome is judged by the word the host actually reads and by the source flag, which must stay clear. Throughout, a bench reference model supplies the expected values.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  parameter int unsigned HPX_WORD_W = 16;
  parameter int unsigned HPX_BYTE_W = 8;
  parameter int unsigned HPX_SYNC_STAGES = 2;
endpackage

// File: rtl/hpx_rst_sync.sv
module hpx_rst_sync #(
  parameter int unsigned STAGES = hpx_pkg::HPX_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hpx_lane.sv
module hpx_lane #(
  parameter int unsigned WORD_W = hpx_pkg::HPX_WORD_W,
  parameter int unsigned BYTE_W = hpx_pkg::HPX_BYTE_W,
  localparam int unsigned NBYTES = WORD_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] ld_mask,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              commit,
  input  logic              rel,
  output logic              src_empty,
  output logic              snk_full,
  output logic [WORD_W-1:0] snk_data
);
  logic [WORD_W-1:0] src_q, src_d;
  logic [WORD_W-1:0] snk_q, snk_d;
  logic              empty_q, empty_d;
  logic              full_q, full_d;
  logic              xfer;

  assign xfer = !empty_q && !full_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_comb begin
      src_d[b*BYTE_W +: BYTE_W] = ld_mask[b] ? ld_data[b*BYTE_W +: BYTE_W]
                                             : src_q[b*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    snk_d   = xfer ? src_q : snk_q;
    empty_d = empty_q;
    if (xfer)   empty_d = 1'b1;
    if (commit) empty_d = 1'b0;
    full_d  = full_q;
    if (rel)    full_d  = 1'b0;
    if (xfer)   full_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      snk_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      src_q   <= src_d;
      snk_q   <= snk_d;
      empty_q <= empty_d;
      full_q  <= full_d;
    end
  end

  assign src_empty = empty_q;
  assign snk_full  = full_q;
  assign snk_data  = snk_q;

  assert_commit_clears_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !src_empty);

  assert_xfer_moves_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_empty && !snk_full) |=> (snk_full && snk_data == $past(src_q)));

  assert_xfer_frees_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_empty && !snk_full && !commit) |=> src_empty);

  assert_release_clears_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_full && rel) |=> !snk_full);

  assert_full_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_full && !rel) |=> (snk_full && $stable(snk_data)));

  assert_collision_keeps_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_empty && !snk_full && commit) |=> (!src_empty && snk_full));
endmodule

// File: rtl/hpx_core_if.sv
module hpx_core_if #(
  parameter int unsigned WORD_W = hpx_pkg::HPX_WORD_W,
  parameter int unsigned BYTE_W = hpx_pkg::HPX_BYTE_W,
  localparam int unsigned NBYTES = WORD_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_wr,
  input  logic              core_rd,
  input  logic [WORD_W-1:0] core_wdata,
  input  logic              tx_ie,
  input  logic              rx_ie,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic [WORD_W-1:0] rx_data,
  output logic [NBYTES-1:0] ld_mask,
  output logic [WORD_W-1:0] ld_data,
  output logic              commit,
  output logic              rel,
  output logic [WORD_W-1:0] core_rdata,
  output logic              tx_irq,
  output logic              rx_irq
);
  always_comb begin
    ld_mask    = {NBYTES{core_wr}};
    ld_data    = core_wdata;
    commit     = core_wr;
    rel        = core_rd;
    core_rdata = rx_data;
    tx_irq     = tx_empty & tx_ie;
    rx_irq     = rx_full & rx_ie;
  end

  assert_tx_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && !tx_ie) |=> !tx_irq);

  assert_rx_read_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && rx_full) |=> !rx_irq);
endmodule

// File: rtl/hpx_host_if.sv
module hpx_host_if #(
  parameter int unsigned WORD_W = hpx_pkg::HPX_WORD_W,
  parameter int unsigned BYTE_W = hpx_pkg::HPX_BYTE_W,
  localparam int unsigned NBYTES = WORD_W / BYTE_W,
  localparam int unsigned SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [WORD_W-1:0] rx_data,
  output logic [NBYTES-1:0] ld_mask,
  output logic [WORD_W-1:0] ld_data,
  output logic              commit,
  output logic              rel,
  output logic [BYTE_W-1:0] host_rdata
);
  logic last_byte;
  assign last_byte = (host_sel == '0);

  for (genvar b = 0; b < NBYTES; b++) begin : g_sel
    assign ld_mask[b] = host_wr && (host_sel == SEL_W'(b));
    assign ld_data[b*BYTE_W +: BYTE_W] = host_wdata;
  end

  always_comb begin
    commit     = host_wr && last_byte;
    rel        = host_rd && last_byte;
    host_rdata = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (host_sel == SEL_W'(b)) host_rdata = rx_data[b*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    assert_mask_onehot_R6: assert ($onehot0(ld_mask));
  end
endmodule

// File: rtl/hostport_xchg.sv
module hostport_xchg #(
  parameter int unsigned WORD_W      = hpx_pkg::HPX_WORD_W,
  parameter int unsigned BYTE_W      = hpx_pkg::HPX_BYTE_W,
  parameter int unsigned SYNC_STAGES = hpx_pkg::HPX_SYNC_STAGES
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 core_wr,
  input  logic                                 core_rd,
  input  logic [WORD_W-1:0]                    core_wdata,
  output logic [WORD_W-1:0]                    core_rdata,
  input  logic                                 core_tx_ie,
  input  logic                                 core_rx_ie,
  output logic                                 core_tx_empty,
  output logic                                 core_rx_full,
  output logic                                 core_tx_irq,
  output logic                                 core_rx_irq,
  input  logic [$clog2(WORD_W/BYTE_W)-1:0]     host_sel,
  input  logic                                 host_wr,
  input  logic                                 host_rd,
  input  logic [BYTE_W-1:0]                    host_wdata,
  output logic [BYTE_W-1:0]                    host_rdata,
  output logic                                 host_tx_empty,
  output logic                                 host_rx_full
);
  localparam int unsigned NBYTES = WORD_W / BYTE_W;

  logic              rst_i_n;
  logic [NBYTES-1:0] c_mask, h_mask;
  logic [WORD_W-1:0] c_ldata, h_ldata;
  logic              c_commit, c_rel, h_commit, h_rel;
  logic [WORD_W-1:0] out_snk, in_snk;

  hpx_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  hpx_core_if #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_core (
    .clk(clk), .rst_n(rst_i_n),
    .core_wr(core_wr), .core_rd(core_rd), .core_wdata(core_wdata),
    .tx_ie(core_tx_ie), .rx_ie(core_rx_ie),
    .tx_empty(core_tx_empty), .rx_full(core_rx_full), .rx_data(in_snk),
    .ld_mask(c_mask), .ld_data(c_ldata), .commit(c_commit), .rel(c_rel),
    .core_rdata(core_rdata), .tx_irq(core_tx_irq), .rx_irq(core_rx_irq)
  );

  hpx_host_if #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_host (
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata), .rx_data(out_snk),
    .ld_mask(h_mask), .ld_data(h_ldata), .commit(h_commit), .rel(h_rel),
    .host_rdata(host_rdata)
  );

  // core -> host direction
  hpx_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_out (
    .clk(clk), .rst_n(rst_i_n),
    .ld_mask(c_mask), .ld_data(c_ldata), .commit(c_commit), .rel(h_rel),
    .src_empty(core_tx_empty), .snk_full(host_rx_full), .snk_data(out_snk)
  );

  // host -> core direction
  hpx_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_in (
    .clk(clk), .rst_n(rst_i_n),
    .ld_mask(h_mask), .ld_data(h_ldata), .commit(h_commit), .rel(c_rel),
    .src_empty(host_tx_empty), .snk_full(core_rx_full), .snk_data(in_snk)
  );

  assert_out_of_reset_R1: assert property (@(posedge clk)
    (!rst_i_n) |=> (core_tx_empty && host_tx_empty && !core_rx_full && !host_rx_full));
endmodule

// File: tb/test_hostport_xchg.sv
module test_hostport_xchg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_wr, core_rd, core_tx_ie, core_rx_ie;
  logic [15:0] core_wdata, core_rdata;
  logic        core_tx_empty, core_rx_full, core_tx_irq, core_rx_irq;
  logic        host_sel, host_wr, host_rd;
  logic [7:0]  host_wdata, host_rdata;
  logic        host_tx_empty, host_rx_full;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [15:0] m_tx, m_hrx, m_htx, m_crx;
  logic        m_tx_e, m_hrx_f, m_htx_e, m_crx_f;

  always #10 clk = ~clk;

  hostport_xchg i_hostport_xchg (
    .clk(clk), .rst_n(rst_n),
    .core_wr(core_wr), .core_rd(core_rd), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_tx_ie(core_tx_ie), .core_rx_ie(core_rx_ie),
    .core_tx_empty(core_tx_empty), .core_rx_full(core_rx_full),
    .core_tx_irq(core_tx_irq), .core_rx_irq(core_rx_irq),
    .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_tx_empty(host_tx_empty), .host_rx_full(host_rx_full)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_hbyte(input logic [15:0] w, input logic sel);
    return sel ? w[15:8] : w[7:0];
  endfunction

  task automatic compare_all();
    chk("R2 core_tx_empty", 16'(core_tx_empty), 16'(m_tx_e));
    chk("R3 host_rx_full",  16'(host_rx_full),  16'(m_hrx_f));
    chk("R3 host_rdata",    16'(host_rdata),    16'(exp_hbyte(m_hrx, host_sel)));
    chk("R6 host_tx_empty", 16'(host_tx_empty), 16'(m_htx_e));
    chk("R7 core_rdata",    core_rdata,         m_crx);
    chk("R8 core_rx_full",  16'(core_rx_full),  16'(m_crx_f));
    chk("R5 core_tx_irq",   16'(core_tx_irq),   16'(m_tx_e & core_tx_ie));
    chk("R8 core_rx_irq",   16'(core_rx_irq),   16'(m_crx_f & core_rx_ie));
  endtask

  // drive one cycle at a negedge, advance the model, compare at the next negedge
  task automatic step(input logic cwr, input logic [15:0] cwd, input logic crd,
                      input logic hsel, input logic hwr, input logic [7:0] hwd,
                      input logic hrd);
    logic x_out, x_in;
    core_wr = cwr; core_wdata = cwd; core_rd = crd;
    host_sel = hsel; host_wr = hwr; host_wdata = hwd; host_rd = hrd;
    x_out = !m_tx_e && !m_hrx_f;
    x_in  = !m_htx_e && !m_crx_f;
    @(negedge clk);
    if (x_out) m_hrx = m_tx;
    if (hrd && !hsel) m_hrx_f = 1'b0;
    if (x_out) m_hrx_f = 1'b1;
    if (x_out) m_tx_e = 1'b1;
    if (cwr) begin m_tx = cwd; m_tx_e = 1'b0; end
    if (x_in) begin m_crx = m_htx; m_htx_e = 1'b1; end
    if (crd) m_crx_f = 1'b0;
    if (x_in) m_crx_f = 1'b1;
    if (hwr && hsel)  m_htx[15:8] = hwd;
    if (hwr && !hsel) begin m_htx[7:0] = hwd; m_htx_e = 1'b0; end
    compare_all();
  endtask

  task automatic idle();
    step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    rst_n = 1'b0;
    core_wr = 0; core_rd = 0; core_wdata = 0; core_tx_ie = 0; core_rx_ie = 0;
    host_sel = 1; host_wr = 0; host_rd = 0; host_wdata = 0;
    m_tx = 0; m_hrx = 0; m_htx = 0; m_crx = 0;
    m_tx_e = 1; m_hrx_f = 0; m_htx_e = 1; m_crx_f = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 core_tx_empty", 16'(core_tx_empty), 16'h1);
    chk("R1 host_tx_empty", 16'(host_tx_empty), 16'h1);
    chk("R1 core_rx_full",  16'(core_rx_full),  16'h0);
    chk("R1 host_rx_full",  16'(host_rx_full),  16'h0);
    chk("R1 core_rdata",    core_rdata,         16'h0);
    chk("R1 host_rdata hi", 16'(host_rdata),    16'h0);
    chk("R1 tx_irq",        16'(core_tx_irq),   16'h0);
    chk("R1 rx_irq",        16'(core_rx_irq),   16'h0);
    core_tx_ie = 1; core_rx_ie = 1;
    #1;
    chk("R5 tx_irq enabled on empty", 16'(core_tx_irq), 16'h1);
    chk("R8 rx_irq idle",             16'(core_rx_irq), 16'h0);

    // R10: back-to-back writes, second meets transfer of first
    step(1'b1, 16'hA1B2, 0, 1, 0, 8'h0, 0);
    chk("R2 write clears empty", 16'(core_tx_empty), 16'h0);
    chk("R5 irq drops", 16'(core_tx_irq), 16'h0);
    step(1'b1, 16'hC3D4, 0, 1, 0, 8'h0, 0);
    chk("R10 host gets older word hi", 16'(host_rdata), 16'h00A1);
    chk("R10 pending stays", 16'(core_tx_empty), 16'h0);
    chk("R3 host full", 16'(host_rx_full), 16'h1);
    idle();
    chk("R11 host word held", 16'(host_rdata), 16'h00A1);
    step(0, 16'h0, 0, 1, 0, 8'h0, 1);
    chk("R4 high read keeps full", 16'(host_rx_full), 16'h1);
    step(0, 16'h0, 0, 0, 0, 8'h0, 1);
    chk("R4 low read clears full", 16'(host_rx_full), 16'h0);
    chk("R3 low byte of older word", 16'(host_rdata), 16'h00B2);
    idle();
    chk("R3 newer word arrives hi", 16'(host_rdata), 16'h00C3);
    chk("R3 core empty again", 16'(core_tx_empty), 16'h1);
    step(0, 16'h0, 0, 0, 0, 8'h0, 1);

    // R9: overwrite while pending
    idle();
    step(1'b1, 16'h1111, 0, 1, 0, 8'h0, 0);
    idle();
    step(1'b1, 16'h2222, 0, 1, 0, 8'h0, 0);
    step(1'b1, 16'h3333, 0, 1, 0, 8'h0, 0);
    step(0, 16'h0, 0, 0, 0, 8'h0, 1);
    idle();
    chk("R9 newest word reaches host", 16'(host_rdata), 16'h0033);
    step(0, 16'h0, 0, 0, 0, 8'h0, 1);

    // R6 R7 R8: host to core
    step(0, 16'h0, 0, 1, 1, 8'h5A, 0);
    chk("R6 high write keeps empty", 16'(host_tx_empty), 16'h1);
    step(0, 16'h0, 0, 0, 1, 8'hC7, 0);
    chk("R6 low write clears empty", 16'(host_tx_empty), 16'h0);
    idle();
    chk("R7 core word", core_rdata, 16'h5AC7);
    chk("R7 core full", 16'(core_rx_full), 16'h1);
    chk("R8 rx_irq", 16'(core_rx_irq), 16'h1);
    step(0, 16'h0, 1, 1, 0, 8'h0, 0);
    chk("R8 read clears full", 16'(core_rx_full), 16'h0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 16) == 0) begin
        core_tx_ie = 1'($urandom);
        core_rx_ie = 1'($urandom);
      end
      step(($urandom % 4) == 0, 16'($urandom), ($urandom % 4) == 0,
           1'($urandom), ($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule